// File: doc/BRIEF.md
# Fail-Safe Output Generator

This block turns a small set of critical fault indications into one internal fail-safe level and uses that level to drive high-side output channel 3. The faults that count depend on the operating mode. During start-up, a regulator that stays below its failure level for a whole timed window counts, but only while the supply is above its under-voltage threshold. In the running modes (normal and standby), three things count: a regulator below its reset level, the second thermal shutdown level, and a watchdog failure. A watchdog failure is held until the next correct trigger. In forced sleep, the level only reports whether the sleep was caused by a failure. In a requested sleep the level is always inactive.

By default the fail-safe level owns channel 3 and the register setting for that channel has no effect. When the disable bit is set, channel 3 becomes an ordinary software-driven high-side output and the fail-safe level stays internal. The level is registered: it changes on the rising edge that samples the causing inputs.

Top module: `failsafe_gen`

## Requirements
- R1: While `rst_n` is low, `fs_o` is 0, and `ch3_drive_o` is 0 when `fs_disable_i` is 0.
- R2: With `fs_disable_i` = 0, `ch3_drive_o` equals `fs_o` whatever the value of `spi_ch3_i`.
- R3: With `fs_disable_i` = 1, `ch3_drive_o` equals `spi_ch3_i`, and `fs_o` still behaves as in R4 to R9.
- R4: In init mode (`mode_i` = 0), `fs_o` goes to 1 on the (SHORT_TICKS+1)-th consecutive rising edge that samples `reg_below_fail_i` = 1 and `supply_ok_i` = 1. It stays 0 before that edge.
- R5: The init window restarts from zero when `reg_below_fail_i` falls, when `supply_ok_i` falls, or when the mode leaves init. `fs_o` returns to 0 on the edge after the qualifying condition ends.
- R6: In normal (`mode_i` = 1) or standby (`mode_i` = 2), `reg_below_rst_i` = 1 sets `fs_o` to 1 on the sampling edge.
- R7: In normal or standby, `therm2_i` = 1 sets `fs_o` to 1 on the sampling edge.
- R8: A sampled `wdg_fail_i` pulse sets a watchdog fault that is cleared only by a sampled `wdg_ok_i`. When both are sampled in the same cycle, the fail wins. In normal or standby the fault drives `fs_o` to 1 from the edge that samples the fail.
- R9: In forced sleep (`mode_i` = 3), `fs_o` follows `fsleep_fault_i`. In requested sleep (`mode_i` = 4), `fs_o` is 0.
- R10: Run-mode terms (reset level, thermal, watchdog) have no effect on `fs_o` in init or in either sleep mode. The init window term has no effect outside init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode: 0 init, 1 normal, 2 standby, 3 forced sleep, 4 requested sleep |
| reg_below_fail_i | input | 1 | Regulator output below its failure level |
| reg_below_rst_i | input | 1 | Regulator output below its reset level |
| supply_ok_i | input | 1 | Supply above its under-voltage threshold |
| wdg_fail_i | input | 1 | Watchdog failed-trigger event, one cycle |
| wdg_ok_i | input | 1 | Watchdog correct-trigger event, one cycle |
| therm2_i | input | 1 | Junction above the second shutdown threshold |
| fsleep_fault_i | input | 1 | Forced sleep was entered because of a failure |
| fs_disable_i | input | 1 | 1 releases channel 3 to the register setting |
| spi_ch3_i | input | 1 | Register setting for channel 3 |
| fs_o | output | 1 | Fail-safe level |
| ch3_drive_o | output | 1 | Final drive of high-side channel 3 |

## Verification
The block is driven with random mode sequences in which modes persist for several cycles and fault flags toggle sparsely, with the disable bit and register setting flipping freely. This separates mode gating (R10) from the fault terms themselves, and the output path (R2, R3) from the level. Directed runs hold the init condition for exactly SHORT_TICKS and SHORT_TICKS+1 edges, and break it by dropping either the regulator flag or the supply flag. These runs show the window length apart from the restart rule. A watchdog fail sent alone, a fail and a correct trigger sent together, and a correct trigger alone show that the latch holds, that fail takes priority, and that the latch clears.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [2:0] {
        FSG_INIT    = 3'd0,
        FSG_NORMAL  = 3'd1,
        FSG_STANDBY = 3'd2,
        FSG_FSLEEP  = 3'd3,
        FSG_RSLEEP  = 3'd4
    } fsg_mode_e;

    typedef struct packed {
        logic fs;
    } fsg_top_state_t;

endpackage

// File: rtl/fsg_short_timer.sv
module fsg_short_timer #(
    parameter int unsigned TICKS = 800_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    // counts consecutive armed cycles, saturating at the limit
    always_comb begin
        st_d = st_q;
        if (!arm_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = arm_i && (st_q.cnt == LIMIT);

endmodule

// File: rtl/fsg_wdg_latch.sv
module fsg_wdg_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic ok_i,
    output logic term_o
);
    typedef struct packed {
        logic held;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fail_i)    st_d.held = 1'b1;   // fail has priority
        else if (ok_i) st_d.held = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a new fail counts in the same cycle it is seen
    assign term_o = fail_i || (st_q.held && !ok_i);

endmodule

// File: rtl/fsg_out_sel.sv
module fsg_out_sel #(
    parameter int unsigned CHANNELS = 1
) (
    input  logic [CHANNELS-1:0] release_i,
    input  logic [CHANNELS-1:0] sw_i,
    input  logic                fs_i,
    output logic [CHANNELS-1:0] drive_o
);
    for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
        assign drive_o[g] = release_i[g] ? sw_i[g] : fs_i;
    end
endmodule

// File: rtl/failsafe_gen.sv
module failsafe_gen
    import fsg_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 800_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       reg_below_fail_i,
    input  logic       reg_below_rst_i,
    input  logic       supply_ok_i,
    input  logic       wdg_fail_i,
    input  logic       wdg_ok_i,
    input  logic       therm2_i,
    input  logic       fsleep_fault_i,
    input  logic       fs_disable_i,
    input  logic       spi_ch3_i,
    output logic       fs_o,
    output logic       ch3_drive_o
);
    fsg_mode_e mode;
    logic in_init, in_run, in_fsleep;
    logic short_arm, short_hit, wdg_term;

    fsg_top_state_t st_d, st_q;

    assign mode      = fsg_mode_e'(mode_i);
    assign in_init   = (mode == FSG_INIT);
    assign in_run    = (mode == FSG_NORMAL) || (mode == FSG_STANDBY);
    assign in_fsleep = (mode == FSG_FSLEEP);
    assign short_arm = in_init && reg_below_fail_i && supply_ok_i;

    fsg_short_timer #(.TICKS(SHORT_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (short_arm),
        .expired_o (short_hit)
    );

    fsg_wdg_latch u_wdg (
        .clk    (clk),
        .rst_n  (rst_n),
        .fail_i (wdg_fail_i),
        .ok_i   (wdg_ok_i),
        .term_o (wdg_term)
    );

    always_comb begin
        st_d = st_q;
        unique case (1'b1)
            in_init:   st_d.fs = short_hit;
            in_run:    st_d.fs = reg_below_rst_i || therm2_i || wdg_term;
            in_fsleep: st_d.fs = fsleep_fault_i;
            default:   st_d.fs = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fs_o = st_q.fs;

    fsg_out_sel #(.CHANNELS(1)) u_sel (
        .release_i (fs_disable_i),
        .sw_i      (spi_ch3_i),
        .fs_i      (st_q.fs),
        .drive_o   (ch3_drive_o)
    );

endmodule

// File: rtl/failsafe_gen_chk.sv
module failsafe_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       reg_below_rst_i,
    input logic       therm2_i,
    input logic       wdg_fail_i,
    input logic       fsleep_fault_i,
    input logic       fs_disable_i,
    input logic       spi_ch3_i,
    input logic       fs_o,
    input logic       ch3_drive_o
);
    logic run_mode;
    assign run_mode = (mode_i == 3'd1) || (mode_i == 3'd2);

    assert_ch3_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_disable_i |-> ch3_drive_o == fs_o);

    assert_ch3_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fs_disable_i |-> ch3_drive_o == spi_ch3_i);

    assert_rst_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && reg_below_rst_i) |=> fs_o);

    assert_thermal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && therm2_i) |=> fs_o);

    assert_wdg_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && wdg_fail_i) |=> fs_o);

    assert_fsleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd3) |=> fs_o == $past(fsleep_fault_i));

    assert_rsleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd4) |=> !fs_o);
endmodule

bind failsafe_gen failsafe_gen_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .reg_below_rst_i (reg_below_rst_i),
    .therm2_i        (therm2_i),
    .wdg_fail_i      (wdg_fail_i),
    .fsleep_fault_i  (fsleep_fault_i),
    .fs_disable_i    (fs_disable_i),
    .spi_ch3_i       (spi_ch3_i),
    .fs_o            (fs_o),
    .ch3_drive_o     (ch3_drive_o)
);

// File: tb/tb_failsafe_gen.sv
module tb_failsafe_gen;
    localparam int unsigned TICKS = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic below_fail = 0, below_rst = 0, sup_ok = 0, wfail = 0, wok = 0;
    logic therm = 0, fsl_fault = 0, dis = 0, spi = 0;
    logic fs, ch3;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    int  m_cnt = 0;
    logic m_lat = 0;
    logic m_fs = 0;

    always #2.5 clk = ~clk;

    failsafe_gen #(.SHORT_TICKS(TICKS)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .reg_below_fail_i(below_fail), .reg_below_rst_i(below_rst),
        .supply_ok_i(sup_ok), .wdg_fail_i(wfail), .wdg_ok_i(wok),
        .therm2_i(therm), .fsleep_fault_i(fsl_fault),
        .fs_disable_i(dis), .spi_ch3_i(spi),
        .fs_o(fs), .ch3_drive_o(ch3)
    );

    function automatic logic exp_fs(input logic [2:0] md, input int cnt, input logic lat);
        logic arm, wt;
        arm = (md == 3'd0) && below_fail && sup_ok;
        wt  = wfail || (lat && !wok);
        case (md)
            3'd0:       return arm && (cnt == TICKS);
            3'd1, 3'd2: return below_rst || therm || wt;
            3'd3:       return fsl_fault;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic exp_ch3(input logic f);
        return dis ? spi : f;
    endfunction

    task automatic check(input string req);
        vectors++;
        if (fs !== m_fs) begin
            miscompares++;
            $display("FAIL %s fs actual=%b expected=%b t=%0t", req, fs, m_fs, $time);
        end
        if (ch3 !== exp_ch3(m_fs)) begin
            miscompares++;
            $display("FAIL %s ch3 actual=%b expected=%b t=%0t", req, ch3, exp_ch3(m_fs), $time);
        end
    endtask

    // inputs already driven at a falling edge; advance one cycle and check
    task automatic step(input string req);
        logic nfs, arm;
        @(posedge clk);
        nfs = exp_fs(mode, m_cnt, m_lat);
        arm = (mode == 3'd0) && below_fail && sup_ok;
        if (!arm) m_cnt = 0;
        else if (m_cnt < TICKS) m_cnt++;
        if (wfail) m_lat = 1;
        else if (wok) m_lat = 0;
        m_fs = nfs;
        @(negedge clk);
        check(req);
    endtask

    task automatic idle();
        mode = 3'd1; below_fail = 0; below_rst = 0; sup_ok = 1; wfail = 0; wok = 1;
        therm = 0; fsl_fault = 0;
        step("R8");
        wok = 0;
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1 reset state
        spi = 1; dis = 0; mode = 3'd1; therm = 1;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1;
        therm = 0; spi = 0;

        // R4 exact window, R2 ownership
        idle();
        mode = 3'd0; below_fail = 1; sup_ok = 1; spi = 1;
        for (int i = 0; i < TICKS; i++) step("R4");
        if (fs !== 1'b0) begin miscompares++; $display("FAIL R4 early actual=%b expected=0", fs); end
        vectors++;
        step("R4");
        if (fs !== 1'b1) begin miscompares++; $display("FAIL R4 late actual=%b expected=1", fs); end
        vectors++;
        step("R2");
        // R5 restart by supply drop
        sup_ok = 0; step("R5");
        sup_ok = 1;
        for (int i = 0; i < TICKS; i++) step("R5");
        below_fail = 0; step("R5");
        below_fail = 1;
        for (int i = 0; i < TICKS + 2; i++) step("R5");
        // R10 window ignored outside init, run terms ignored in init
        mode = 3'd4; step("R10");
        mode = 3'd0; below_fail = 0; below_rst = 1; therm = 1; wfail = 1; step("R10");
        wfail = 0; step("R10");
        below_rst = 0; therm = 0;

        // R8 hold, priority, clear
        mode = 3'd2; wok = 1; step("R8");
        wok = 0; wfail = 1; step("R8");
        wfail = 0; repeat (3) step("R8");
        wok = 1; step("R8");
        wok = 0; step("R8");
        wfail = 1; wok = 1; step("R8");
        wfail = 0; wok = 0; repeat (2) step("R8");
        wok = 1; step("R8");
        wok = 0;
        // R6, R7
        below_rst = 1; step("R6");
        below_rst = 0; step("R6");
        therm = 1; mode = 3'd1; step("R7");
        therm = 0; step("R7");
        // R9
        mode = 3'd3; fsl_fault = 1; step("R9");
        fsl_fault = 0; step("R9");
        mode = 3'd4; fsl_fault = 1; therm = 1; step("R9");
        therm = 0; fsl_fault = 0;
        // R3 release
        dis = 1; mode = 3'd1; therm = 1; spi = 0; step("R3");
        spi = 1; therm = 0; step("R3");
        dis = 0;

        // constrained random, modes persist
        for (int v = 0; v < 4000; v++) begin
            if ($urandom_range(9) == 0) mode = 3'($urandom_range(4));
            if (mode == 3'd0 && $urandom_range(1) == 0) begin
                below_fail = 1; sup_ok = 1;
            end else begin
                below_fail = ($urandom_range(3) != 0);
                sup_ok     = ($urandom_range(5) != 0);
            end
            below_rst = ($urandom_range(15) == 0);
            therm     = ($urandom_range(15) == 0);
            wfail     = ($urandom_range(19) == 0);
            wok       = ($urandom_range(9) == 0);
            fsl_fault = $urandom_range(1) == 1;
            dis       = ($urandom_range(3) == 0);
            spi       = $urandom_range(1) == 1;
            step(dis ? "R3" : "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule